// File: doc/BRIEF.md
# Private Interrupt State Bank

This block stores the per-interrupt state of 32 interrupts that belong to one processor. IDs 0 to 15 are software-generated and IDs 16 to 31 are peripheral. For each ID it holds an 8-bit priority, a group bit, a group modifier bit, an enable bit, a pending bit, an active bit, an edge/level trigger selection and a 2-bit field that controls which software requests from the non-secure side are accepted. The group bit and the modifier bit together decode into one of three security groups.

Software reaches the state through a word-addressed register bus. Each access carries a non-secure attribute. Reads are combinational in the same cycle. Writes take effect at the next clock edge. Hardware event inputs do four things: they raise peripheral interrupts, they deliver software interrupts that carry a requested group and a security attribute, and they activate or deactivate an ID. A packed status vector reports the pending and active pair of every ID, one cycle after any change.

Top module: `pirq_state_bank`

## Requirements
- R1: After reset, all enable, pending, active, group, modifier, trigger and access bits are 0, every priority is 0, and `irq_status` is all zero.
- R2: The bitmap words use these addresses: word 2 sets enables, word 3 clears enables, word 4 sets pending, word 5 clears pending, word 6 sets active and word 7 clears active. Bit n of each word is ID n. Writing a 1 sets or clears that bit, and writing a 0 leaves it unchanged. Both words of a pair read back the current bitmap.
- R3: The decoded group is Secure Group 0 when group=0 and modifier=0. It is Secure Group 1 when group=0 and modifier=1. It is Non-secure Group 1 when group=1, whatever the modifier. On a non-secure access, every ID that is not Non-secure Group 1 reads as 0 in every word, and writes to its bits have no effect.
- R4: Words 16 to 23 hold priorities: word 16+j holds IDs 4j to 4j+3, and ID 4j+b sits in byte b. A byte is written only when `bus_be[b]` is 1.
- R5: Words 8 (IDs 0 to 15) and 9 (IDs 16 to 31) hold trigger pairs at bits 2k+1:2k for ID base+k. The upper bit set means edge-triggered. The lower bit always reads 0.
- R6: Word 0 holds the group bits, word 1 the modifier bits, and words 10 and 11 the 2-bit access fields at bits 2k+1:2k. A non-secure access reads these four words as 0, and its writes to them are ignored.
- R7: `act_valid` clears the pending bit of `act_id` and sets its active bit.
- R8: `deact_valid` clears only the active bit of `deact_id`.
- R9: `ppi_valid` sets the pending bit of `ppi_id` only when that ID is 16 or above. Lower IDs are ignored.
- R10: A software request (`sgi_grp`: 0 = Secure Group 0, 1 = Secure Group 1, 2 = Non-secure Group 1, 3 = never accepted) is accepted only for IDs 0 to 15. When it is secure, it sets pending only when the requested group equals the target's decoded group.
- R11: A non-secure software request must also match the target's group. For a secure target it is then gated by the access field: 0 blocks it, 1 allows only Secure Group 0 targets, and 2 or 3 allow both secure groups.
- R12: `irq_status[2n+1:2n]` is 0 for inactive, 1 for pending, 2 for active and 3 for active and pending.
- R13: Within one cycle, the effects apply in this order: the bus write, then the peripheral and software requests, then activate, then deactivate. A later effect overrides an earlier one on the same ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ns | input | 1 | Access is non-secure |
| bus_addr | input | 5 | Word address |
| bus_be | input | 4 | Byte enables, used by priority words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ppi_valid | input | 1 | Raise a peripheral interrupt |
| ppi_id | input | 5 | Peripheral interrupt ID |
| sgi_valid | input | 1 | Software interrupt request |
| sgi_id | input | 5 | Software interrupt ID |
| sgi_grp | input | 2 | Requested group |
| sgi_ns | input | 1 | Request is non-secure |
| act_valid | input | 1 | Activate request |
| act_id | input | 5 | ID to activate |
| deact_valid | input | 1 | Deactivate request |
| deact_id | input | 5 | ID to deactivate |
| irq_status | output | 64 | Two-bit status per ID |

## Verification
Directed sequences build up a mix of group and modifier settings and then repeat the same accesses as secure and as non-secure. This separates a correct visibility mask from one that is missing or keyed to the wrong bit. Software requests are sent in every combination of requested group, security attribute and access field, which shows whether gating depends on the decoded group or only on the raw bits. Same-cycle collisions of peripheral, activate and deactivate events on one ID expose ordering faults. A long random phase mixes bus traffic and events and compares every read and every status vector with a bench model.

// File: rtl/pirq_state_bank.sv
module pirq_state_bank #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  parameter int PRIO_W  = 8,
  parameter int AW      = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic                     bus_ns,
  input  logic [AW-1:0]            bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     ppi_valid,
  input  logic [$clog2(NUM_IRQ)-1:0] ppi_id,
  input  logic                     sgi_valid,
  input  logic [$clog2(NUM_IRQ)-1:0] sgi_id,
  input  logic [1:0]               sgi_grp,
  input  logic                     sgi_ns,
  input  logic                     act_valid,
  input  logic [$clog2(NUM_IRQ)-1:0] act_id,
  input  logic                     deact_valid,
  input  logic [$clog2(NUM_IRQ)-1:0] deact_id,
  output logic [2*NUM_IRQ-1:0]     irq_status
);
  localparam int ID_W   = $clog2(NUM_IRQ);
  localparam int PER_W  = 16;
  localparam int A_GRP  = 0;
  localparam int A_MOD  = 1;
  localparam int A_ENS  = 2;
  localparam int A_ENC  = 3;
  localparam int A_PS   = 4;
  localparam int A_PC   = 5;
  localparam int A_AS   = 6;
  localparam int A_AC   = 7;
  localparam int A_CFG  = 8;
  localparam int A_ACC  = 10;
  localparam int A_PRIO = 16;
  localparam logic [ID_W-1:0] SGI_LIM = ID_W'(NUM_SGI);
  localparam logic [1:0] G_S0 = 2'd0, G_S1 = 2'd1, G_NS1 = 2'd2;

  logic [NUM_IRQ-1:0] grp_q, mod_q, en_q, pend_q, act_q;
  logic [NUM_IRQ-1:0] en_d, pend_d, act_d;
  logic [NUM_IRQ-1:0] edge_w;
  logic [2*NUM_IRQ-1:0] acc_w;
  logic [PRIO_W*NUM_IRQ-1:0] prio_w;

  wire wr = bus_en & bus_we;
  wire [NUM_IRQ-1:0] vis = bus_ns ? grp_q : '1;
  wire [NUM_IRQ-1:0] wm  = bus_wdata[NUM_IRQ-1:0] & vis;

  function automatic logic [1:0] decode_grp(input logic g, input logic m);
    return g ? G_NS1 : (m ? G_S1 : G_S0);
  endfunction

  logic [1:0] sgi_tg, sgi_acc;
  logic       sgi_ok;
  always_comb begin
    sgi_tg  = decode_grp(grp_q[sgi_id], mod_q[sgi_id]);
    sgi_acc = acc_w[{sgi_id, 1'b0} +: 2];
    sgi_ok  = 1'b0;
    if (sgi_valid && sgi_id < SGI_LIM && sgi_grp == sgi_tg) begin
      if (!sgi_ns || sgi_tg == G_NS1) sgi_ok = 1'b1;
      else if (sgi_tg == G_S0)        sgi_ok = (sgi_acc != 2'd0);
      else                            sgi_ok = sgi_acc[1];
    end
  end

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    act_d  = act_q;
    if (wr) begin
      if (bus_addr == AW'(A_ENS)) en_d   = en_q   |  wm;
      if (bus_addr == AW'(A_ENC)) en_d   = en_q   & ~wm;
      if (bus_addr == AW'(A_PS))  pend_d = pend_q |  wm;
      if (bus_addr == AW'(A_PC))  pend_d = pend_q & ~wm;
      if (bus_addr == AW'(A_AS))  act_d  = act_q  |  wm;
      if (bus_addr == AW'(A_AC))  act_d  = act_q  & ~wm;
    end
    if (ppi_valid && ppi_id >= SGI_LIM) pend_d[ppi_id] = 1'b1;
    if (sgi_ok) pend_d[sgi_id] = 1'b1;
    if (act_valid) begin
      pend_d[act_id] = 1'b0;
      act_d[act_id]  = 1'b1;
    end
    if (deact_valid) act_d[deact_id] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      mod_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr && !bus_ns && bus_addr == AW'(A_GRP)) grp_q <= bus_wdata[NUM_IRQ-1:0];
      if (wr && !bus_ns && bus_addr == AW'(A_MOD)) mod_q <= bus_wdata[NUM_IRQ-1:0];
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    localparam int CW = A_CFG + i / PER_W;
    localparam int CB = 2 * (i % PER_W);
    localparam int PW = A_PRIO + i / 4;
    localparam int PB = i % 4;
    logic              edge_r;
    logic [1:0]        acc_r;
    logic [PRIO_W-1:0] prio_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edge_r <= 1'b0;
        acc_r  <= 2'd0;
        prio_r <= '0;
      end else if (wr) begin
        if (vis[i] && bus_addr == AW'(CW)) edge_r <= bus_wdata[CB+1];
        if (!bus_ns && bus_addr == AW'(A_ACC + i / PER_W)) acc_r <= bus_wdata[CB +: 2];
        if (vis[i] && bus_be[PB] && bus_addr == AW'(PW)) prio_r <= bus_wdata[8*PB +: PRIO_W];
      end
    end
    assign edge_w[i]                    = edge_r;
    assign acc_w[2*i +: 2]              = acc_r;
    assign prio_w[PRIO_W*i +: PRIO_W]   = prio_r;
    assign irq_status[2*i +: 2]         = {act_q[i], pend_q[i]};
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      if (!bus_ns && bus_addr == AW'(A_GRP)) bus_rdata = grp_q;
      if (!bus_ns && bus_addr == AW'(A_MOD)) bus_rdata = mod_q;
      if (bus_addr == AW'(A_ENS) || bus_addr == AW'(A_ENC)) bus_rdata = en_q & vis;
      if (bus_addr == AW'(A_PS)  || bus_addr == AW'(A_PC))  bus_rdata = pend_q & vis;
      if (bus_addr == AW'(A_AS)  || bus_addr == AW'(A_AC))  bus_rdata = act_q & vis;
      for (int id = 0; id < NUM_IRQ; id++) begin
        if (bus_addr == AW'(A_CFG + id / PER_W))
          bus_rdata[2*(id%PER_W)+1] = edge_w[id] & vis[id];
        if (!bus_ns && bus_addr == AW'(A_ACC + id / PER_W))
          bus_rdata[2*(id%PER_W) +: 2] = acc_w[2*id +: 2];
        if (bus_addr == AW'(A_PRIO + id / 4))
          bus_rdata[8*(id%4) +: PRIO_W] = vis[id] ? prio_w[PRIO_W*id +: PRIO_W] : '0;
      end
    end
  end
endmodule

// File: rtl/pirq_state_bank_chk.sv
module pirq_state_bank_chk #(
  parameter int NUM_IRQ = 32,
  parameter int AW      = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_en,
  input logic                       bus_we,
  input logic                       bus_ns,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_rdata,
  input logic                       ppi_valid,
  input logic [$clog2(NUM_IRQ)-1:0] ppi_id,
  input logic                       act_valid,
  input logic [$clog2(NUM_IRQ)-1:0] act_id,
  input logic                       deact_valid,
  input logic [$clog2(NUM_IRQ)-1:0] deact_id,
  input logic [NUM_IRQ-1:0]         grp,
  input logic [NUM_IRQ-1:0]         pend,
  input logic [NUM_IRQ-1:0]         act,
  input logic [2*NUM_IRQ-1:0]       irq_status
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> irq_status == '0);

  a_r7_act_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> !pend[$past(act_id)]);

  a_r7_act_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !(deact_valid && deact_id == act_id) |=> act[$past(act_id)]);

  a_r8_deact_clears: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |=> !act[$past(deact_id)]);

  a_r9_ppi_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ppi_valid && ppi_id >= 16 && !(act_valid && act_id == ppi_id) && !(bus_en && bus_we)
    |=> pend[$past(ppi_id)]);

  a_r3_ns_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_ns && bus_addr >= AW'(2) && bus_addr <= AW'(7) |-> (bus_rdata & ~grp) == '0);
endmodule

bind pirq_state_bank pirq_state_bank_chk #(.NUM_IRQ(NUM_IRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_ns(bus_ns),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ppi_valid(ppi_valid), .ppi_id(ppi_id),
  .act_valid(act_valid), .act_id(act_id), .deact_valid(deact_valid), .deact_id(deact_id),
  .grp(grp_q), .pend(pend_q), .act(act_q), .irq_status(irq_status));

// File: tb/pirq_state_bank_test.sv
`timescale 1ns/100ps
module pirq_state_bank_test;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0, bus_ns = 0;
  logic [4:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ppi_valid = 0, sgi_valid = 0, sgi_ns = 0, act_valid = 0, deact_valid = 0;
  logic [4:0] ppi_id = 0, sgi_id = 0, act_id = 0, deact_id = 0;
  logic [1:0] sgi_grp = 0;
  logic [63:0] irq_status;

  int checks = 0, fails = 0;
  logic [31:0] rd_seen, rd_exp;
  logic [31:0] m_grp, m_mod, m_en, m_pend, m_act, m_edge;
  logic [63:0] m_acc;
  logic [7:0]  m_prio [32];

  always #2.5 clk = ~clk;

  pirq_state_bank uut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a, input logic ns);
    logic [31:0] v = ns ? m_grp : '1;
    logic [31:0] r = '0;
    if (!ns && a == 0) r = m_grp;
    if (!ns && a == 1) r = m_mod;
    if (a == 2 || a == 3) r = m_en & v;
    if (a == 4 || a == 5) r = m_pend & v;
    if (a == 6 || a == 7) r = m_act & v;
    for (int k = 0; k < 16; k++) begin
      int id = (a[0] ? 16 : 0) + k;
      if (a == 8 || a == 9) r[2*k+1] = m_edge[id] & v[id];
      if (!ns && (a == 10 || a == 11)) r[2*k +: 2] = m_acc[2*id +: 2];
    end
    if (a >= 16 && a <= 23)
      for (int b = 0; b < 4; b++) begin
        int id = (a - 16) * 4 + b;
        r[8*b +: 8] = v[id] ? m_prio[id] : 8'h0;
      end
    return r;
  endfunction

  task automatic m_update();
    logic [31:0] v = bus_ns ? m_grp : '1;
    logic [31:0] wm = bus_wdata & v;
    logic [1:0] tg = m_grp[sgi_id] ? 2'd2 : (m_mod[sgi_id] ? 2'd1 : 2'd0);
    logic [1:0] ac = m_acc[2*sgi_id +: 2];
    logic ok = 0;
    if (sgi_valid && sgi_id < 16 && sgi_grp == tg)
      ok = (!sgi_ns || tg == 2) ? 1'b1 : (tg == 0 ? ac != 0 : ac[1]);
    if (bus_en && bus_we) begin
      case (bus_addr)
        0: if (!bus_ns) m_grp = bus_wdata;
        1: if (!bus_ns) m_mod = bus_wdata;
        2: m_en = m_en | wm;   3: m_en = m_en & ~wm;
        4: m_pend = m_pend | wm; 5: m_pend = m_pend & ~wm;
        6: m_act = m_act | wm; 7: m_act = m_act & ~wm;
        default: ;
      endcase
      for (int k = 0; k < 16; k++) begin
        int id = (bus_addr[0] ? 16 : 0) + k;
        if ((bus_addr == 8 || bus_addr == 9) && v[id]) m_edge[id] = bus_wdata[2*k+1];
        if ((bus_addr == 10 || bus_addr == 11) && !bus_ns) m_acc[2*id +: 2] = bus_wdata[2*k +: 2];
      end
      if (bus_addr >= 16 && bus_addr <= 23)
        for (int b = 0; b < 4; b++) begin
          int id = (bus_addr - 16) * 4 + b;
          if (bus_be[b] && v[id]) m_prio[id] = bus_wdata[8*b +: 8];
        end
    end
    if (ppi_valid && ppi_id >= 16) m_pend[ppi_id] = 1;
    if (ok) m_pend[sgi_id] = 1;
    if (act_valid) begin m_pend[act_id] = 0; m_act[act_id] = 1; end
    if (deact_valid) m_act[deact_id] = 0;
  endtask

  function automatic logic [63:0] m_status();
    logic [63:0] s;
    for (int i = 0; i < 32; i++) s[2*i +: 2] = {m_act[i], m_pend[i]};
    return s;
  endfunction

  task automatic idle();
    bus_en = 0; bus_we = 0; ppi_valid = 0; sgi_valid = 0; act_valid = 0; deact_valid = 0;
  endtask

  task automatic step();
    #1 rd_seen = bus_rdata;
    rd_exp = bus_en ? m_read(bus_addr, bus_ns) : 32'h0;
    @(posedge clk);
    m_update();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic wr32(input int a, input logic [31:0] d, input logic ns, input logic [3:0] be = 4'hF);
    bus_en = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d; bus_ns = ns; bus_be = be;
    step();
  endtask

  task automatic rd32(input int a, input logic ns, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = 5'(a); bus_ns = ns;
    step();
    d = rd_seen;
  endtask

  task automatic sgi(input int id, input logic [1:0] g, input logic ns);
    sgi_valid = 1; sgi_id = 5'(id); sgi_grp = g; sgi_ns = ns;
    step();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    m_grp = 0; m_mod = 0; m_en = 0; m_pend = 0; m_act = 0; m_edge = 0; m_acc = 0;
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 status", irq_status, 64'h0);
    rd32(2, 0, d);  chk("R1 enable", d, 0);
    rd32(16, 0, d); chk("R1 priority", d, 0);
    rd32(0, 0, d);  chk("R1 group", d, 0);

    wr32(2, 32'hF0, 0); rd32(2, 0, d); chk("R2 set", d, 32'hF0);
    wr32(2, 32'h0, 0);  rd32(3, 0, d); chk("R2 zero no effect", d, 32'hF0);
    wr32(3, 32'h10, 0); rd32(2, 0, d); chk("R2 clear", d, 32'hE0);

    wr32(0, 32'h60, 0); wr32(1, 32'h40, 0);
    rd32(2, 1, d); chk("R3 ns read masked", d, 32'h60);
    wr32(3, 32'hFFFF_FFFF, 1); rd32(2, 0, d); chk("R3 ns write masked", d, 32'h80);
    rd32(0, 1, d); chk("R6 ns group hidden", d, 0);

    wr32(17, 32'hAABB_CCDD, 0, 4'b0101);
    rd32(17, 0, d); chk("R4 byte strobes", d, 32'h00BB_00DD);
    rd32(17, 1, d); chk("R4 ns priority read", d, 32'h00BB_0000);
    wr32(17, 32'h1122_3344, 1);
    rd32(17, 0, d); chk("R4 ns priority write", d, 32'h0022_33DD);

    wr32(9, 32'hFFFF_FFFF, 0); rd32(9, 0, d); chk("R5 edge bits", d, 32'hAAAA_AAAA);
    wr32(8, 32'hFFFF_FFFF, 1); rd32(8, 0, d); chk("R5 ns cfg write", d, 32'h0000_2800);

    wr32(10, 32'h9, 0);
    rd32(10, 1, d); chk("R6 ns access hidden", d, 0);
    wr32(10, 32'hFFFF_FFFF, 1);
    rd32(10, 0, d); chk("R6 access fields", d, 32'h9);

    wr32(1, 32'h42, 0);
    sgi(0, 0, 1); chk("R11 acc1 group0 accepted", irq_status[1:0], 2'd1);
    sgi(2, 0, 1); chk("R11 acc0 blocked", irq_status[5:4], 2'd0);
    sgi(1, 0, 1); chk("R11 group mismatch", irq_status[3:2], 2'd0);
    sgi(1, 1, 1); chk("R11 acc2 secure group1", irq_status[3:2], 2'd1);
    sgi(3, 2, 0); chk("R10 wrong group", irq_status[7:6], 2'd0);
    sgi(3, 0, 0); chk("R10 secure match", irq_status[7:6], 2'd1);
    sgi(20, 0, 0); chk("R10 id out of range", irq_status[41:40], 2'd0);

    wr32(5, 32'hF, 1); chk("R3 ns clear hidden pending", irq_status[1:0], 2'd1);

    ppi_valid = 1; ppi_id = 10; step(); chk("R9 low id ignored", irq_status[21:20], 2'd0);
    ppi_valid = 1; ppi_id = 20; step(); chk("R9 pend", irq_status[41:40], 2'd1);
    act_valid = 1; act_id = 20; step(); chk("R7 activate", irq_status[41:40], 2'd2);
    ppi_valid = 1; ppi_id = 20; step(); chk("R12 active and pending", irq_status[41:40], 2'd3);
    deact_valid = 1; deact_id = 20; step(); chk("R8 deactivate", irq_status[41:40], 2'd1);
    ppi_valid = 1; ppi_id = 20; act_valid = 1; act_id = 20; step();
    chk("R13 activate after raise", irq_status[41:40], 2'd2);
    act_valid = 1; act_id = 20; deact_valid = 1; deact_id = 20; step();
    chk("R13 deactivate last", irq_status[41:40], 2'd0);

    for (int n = 0; n < 3000; n++) begin
      bus_en = $urandom % 2; bus_we = $urandom % 2; bus_ns = $urandom % 2;
      bus_addr = 5'($urandom % 24); bus_wdata = $urandom; bus_be = 4'($urandom);
      ppi_valid = ($urandom % 4) == 0; ppi_id = 5'($urandom);
      sgi_valid = ($urandom % 3) == 0; sgi_id = 5'($urandom % 20);
      sgi_grp = 2'($urandom); sgi_ns = $urandom % 2;
      act_valid = ($urandom % 5) == 0; act_id = 5'($urandom);
      deact_valid = ($urandom % 5) == 0; deact_id = 5'($urandom);
      step();
      chk("R2 random read", {32'h0, rd_seen}, {32'h0, rd_exp});
      chk("R12 random status", irq_status, m_status());
    end
    finish_run();
  end
endmodule